// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves one byte at a time over a three-wire clocked serial link: a serial clock it generates itself, a data output and a data input. A single 8-bit buffer serves both directions. The outgoing byte is shifted out of the buffer and the incoming bits are shifted into the same buffer. When a byte completes, the buffer holds the byte that was received. Software loads the buffer and the bit-period reload value. It then starts a transfer by writing the run bit of the control register.

A byte may go out least significant bit first or most significant bit first. A transfer is either a single byte or continuous. In continuous mode the engine re-sends the buffer back to back until software stops it. A sticky end flag marks each completed byte and can raise an interrupt request. A sticky overrun flag records a falling clock edge that arrives while the end flag has not been cleared. When no transfer is running, the serial clock rests low, and a control bit selects what the data line rests at.

Top module: `sio_shift_port`

## Requirements
- R1: After reset, ctrl_q and buf_q read 0, and sck_o, sdo_o and irq_o are 0.
- R2: Each half period of sck_o lasts (256 − baud) system cycles, where baud is the value written with reg_sel=2. A single-byte transfer therefore sets the end flag exactly 16 × (256 − baud) clock edges after the control write that starts it.
- R3: With control bit 1 set, the byte goes out most significant bit first; with it clear, least significant bit first. sdo_o changes only on a falling sck_o edge and is stable at each rising edge.
- R4: sdi_i is sampled on each rising sck_o edge. At the end of a byte, buf_q holds the received bits in the order selected by control bit 1.
- R5: In single mode (control bit 2 clear), run (control bit 0) clears itself at the end of the byte. sck_o is 0 whenever run is 0.
- R6: The end flag (control bit 5) is set when a byte completes. It stays set until a control write carries 0 in bit 5; a write carrying 1 leaves it unchanged.
- R7: A falling sck_o edge while the end flag is set sets the overrun flag (control bit 6). The overrun flag is sticky until a control write carries 0 in bit 6.
- R8: In continuous mode (control bit 2 set), bytes follow back to back with no gap and run stays 1. Each later byte re-sends the buffer, which is the byte just received, and the end flag is set at every byte boundary.
- R9: A control write with bit 0 = 0 during a transfer stops it at once: run reads 0, sck_o drops to 0 and stays there, and the end flag is not set.
- R10: While idle, sdo_o equals buf_q[0] if control bit 3 is 1. If control bit 3 is 0, sdo_o holds the last bit that was shifted out.
- R11: irq_o is 1 exactly when the interrupt enable (control bit 4) and the end flag are both 1.
- R12: Writes to the buffer (reg_sel=1) while run is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 buffer, 2 baud reload |
| reg_wdata | input | 8 | Register write data |
| ctrl_q | output | 8 | Control and status: bit0 run, bit1 MSB first, bit2 continuous, bit3 idle drives buffer bit 0, bit4 interrupt enable, bit5 end flag, bit6 overrun |
| buf_q | output | 8 | Shared transmit/receive buffer |
| sck_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| irq_o | output | 1 | Transfer-end interrupt request |

## Verification
Register writes appear on ctrl_q and buf_q one edge after the write. For a start write at edge E0 with half period H = 256 − baud, the first rising sck_o edge falls on edge E0+H. The end flag, the cleared run bit and the received buffer appear together on edge E0+16H. In continuous mode the overrun flag appears on edge E0+18H when the first end flag is left uncleared. The bench counts clock edges from each write and samples on the falling clock edge just before and just after each due edge, so an early or late result is caught. Bits on the serial wire are captured at each rising sck_o edge and compared with the order the bench computes from the chosen bit order.

// File: rtl/sio_port_pkg.sv
package sio_port_pkg;

  // control register field positions
  localparam int CTL_RUN  = 0;
  localparam int CTL_MSB  = 1;
  localparam int CTL_CONT = 2;
  localparam int CTL_IDLE = 3;
  localparam int CTL_IEN  = 4;
  localparam int CTL_DONE = 5;
  localparam int CTL_OVR  = 6;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BUF  = 2'd1,
    SEL_BAUD = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/sio_baud_gen.sv
module sio_baud_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [CW-1:0] reload,
  output logic          tick
);
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] tmr;

  // next timer value: counts up from the reload value to all ones
  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] cur,
                                               input logic [CW-1:0] rl);
    return (cur == TOP) ? rl : cur + 1'b1;
  endfunction

  assign tick = run && !restart && (tmr == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmr <= '0;
    else if (restart) tmr <= reload;
    else if (run)     tmr <= next_count(tmr, reload);
  end
endmodule

// File: rtl/sio_shift_reg.sv
module sio_shift_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          clr_cnt,
  input  logic          rise_evt,
  input  logic          fall_evt,
  input  logic          msb_first,
  input  logic          sdi,
  output logic [DW-1:0] buf_q,
  output logic          cur_bit,
  output logic          last_bit,
  output logic          byte_end
);
  localparam int CNT_W = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DW - 1);

  logic [CNT_W-1:0] cnt;
  logic             rx_bit;

  // one shift step: the sampled bit enters at the end opposite the outgoing one
  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] cur,
                                             input logic din,
                                             input logic msb);
    return msb ? {cur[DW-2:0], din} : {din, cur[DW-1:1]};
  endfunction

  assign cur_bit  = msb_first ? buf_q[DW-1] : buf_q[0];
  assign byte_end = fall_evt && (cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      rx_bit   <= 1'b0;
      last_bit <= 1'b0;
    end else begin
      if (load)          buf_q <= load_data;
      else if (fall_evt) buf_q <= shift_in(buf_q, rx_bit, msb_first);
      if (rise_evt)      rx_bit <= sdi;
      if (fall_evt)      last_bit <= cur_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr_cnt)  cnt <= '0;
    else if (fall_evt) cnt <= byte_end ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/sio_ctl.sv
module sio_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic wr_msb,
  input  logic wr_cont,
  input  logic wr_idle,
  input  logic wr_ien,
  input  logic wr_done,
  input  logic wr_ovr,
  input  logic byte_end,
  input  logic fall_evt,
  output logic msb_first,
  output logic cont_mode,
  output logic idle_buf0,
  output logic irq_en,
  output logic done,
  output logic ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_first <= 1'b0;
      cont_mode <= 1'b0;
      idle_buf0 <= 1'b0;
      irq_en    <= 1'b0;
    end else if (ctl_wr) begin
      msb_first <= wr_msb;
      cont_mode <= wr_cont;
      idle_buf0 <= wr_idle;
      irq_en    <= wr_ien;
    end
  end

  // sticky flags: hardware set wins over a software clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (byte_end)               done <= 1'b1;
      else if (ctl_wr && !wr_done) done <= 1'b0;
      if (fall_evt && done)       ovr <= 1'b1;
      else if (ctl_wr && !wr_ovr) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_shift_port.sv
module sio_shift_port
  import sio_port_pkg::*;
#(
  parameter int DW     = 8,
  parameter int BAUD_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] buf_q,
  output logic          sck_o,
  output logic          sdo_o,
  input  logic          sdi_i,
  output logic          irq_o
);
  logic              active;
  logic              ctl_wr, buf_wr, baud_wr;
  logic              start_evt, abort_evt, stop_evt;
  logic              tick_raw, tick, rise_evt, fall_evt, byte_end;
  logic              msb_first, cont_mode, idle_buf0, irq_en, done, ovr;
  logic              cur_bit, last_bit;
  logic [BAUD_W-1:0] baud_q;

  assign ctl_wr  = reg_we && (reg_sel == SEL_CTRL);
  assign buf_wr  = reg_we && (reg_sel == SEL_BUF) && !active;
  assign baud_wr = reg_we && (reg_sel == SEL_BAUD);

  assign start_evt = ctl_wr &&  reg_wdata[CTL_RUN] && !active;
  assign abort_evt = ctl_wr && !reg_wdata[CTL_RUN] &&  active;

  assign tick     = tick_raw && !abort_evt;
  assign rise_evt = tick && !sck_o;
  assign fall_evt = tick &&  sck_o;
  assign stop_evt = byte_end && !cont_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       baud_q <= '0;
    else if (baud_wr) baud_q <= reg_wdata[BAUD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sck_o  <= 1'b0;
    end else if (start_evt) begin
      active <= 1'b1;
      sck_o  <= 1'b0;
    end else if (abort_evt || stop_evt) begin
      active <= 1'b0;
      sck_o  <= 1'b0;
    end else if (tick) begin
      sck_o  <= !sck_o;
    end
  end

  sio_baud_gen #(.CW(BAUD_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_evt),
    .run     (active),
    .reload  (baud_q),
    .tick    (tick_raw)
  );

  sio_shift_reg #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (buf_wr),
    .load_data (reg_wdata),
    .clr_cnt   (start_evt || abort_evt),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .msb_first (msb_first),
    .sdi       (sdi_i),
    .buf_q     (buf_q),
    .cur_bit   (cur_bit),
    .last_bit  (last_bit),
    .byte_end  (byte_end)
  );

  sio_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .wr_msb    (reg_wdata[CTL_MSB]),
    .wr_cont   (reg_wdata[CTL_CONT]),
    .wr_idle   (reg_wdata[CTL_IDLE]),
    .wr_ien    (reg_wdata[CTL_IEN]),
    .wr_done   (reg_wdata[CTL_DONE]),
    .wr_ovr    (reg_wdata[CTL_OVR]),
    .byte_end  (byte_end),
    .fall_evt  (fall_evt),
    .msb_first (msb_first),
    .cont_mode (cont_mode),
    .idle_buf0 (idle_buf0),
    .irq_en    (irq_en),
    .done      (done),
    .ovr       (ovr)
  );

  assign sdo_o = active ? cur_bit : (idle_buf0 ? buf_q[0] : last_bit);
  assign irq_o = irq_en && done;

  always_comb begin
    ctrl_q           = '0;
    ctrl_q[CTL_RUN]  = active;
    ctrl_q[CTL_MSB]  = msb_first;
    ctrl_q[CTL_CONT] = cont_mode;
    ctrl_q[CTL_IDLE] = idle_buf0;
    ctrl_q[CTL_IEN]  = irq_en;
    ctrl_q[CTL_DONE] = done;
    ctrl_q[CTL_OVR]  = ovr;
  end
endmodule

// File: rtl/sio_shift_port_chk.sv
module sio_shift_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          cont,
  input logic          done,
  input logic          ovr,
  input logic          sck,
  input logic [DW-1:0] bufv,
  input logic          fall_evt,
  input logic          byte_end
);
  // R5
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sck);

  // R5
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && !cont) |=> !run);

  // R6
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(sck) && !sck));

  // R7
  ovr_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(done));

  // R12
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(fall_evt)) |-> $stable(bufv));
endmodule

bind sio_shift_port sio_shift_port_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (active),
  .cont     (cont_mode),
  .done     (done),
  .ovr      (ovr),
  .sck      (sck_o),
  .bufv     (buf_q),
  .fall_evt (fall_evt),
  .byte_end (byte_end)
);

// File: tb/sio_shift_port_test.sv
module sio_shift_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] ctrl_q, buf_q;
  logic       sck_o, sdo_o, irq_o;
  logic       sdi_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] slv_seq = '0;
  logic [31:0] cap_seq = '0;
  int slv_idx = 0;
  int cap_idx = 0;

  always #2 clk = ~clk;

  sio_shift_port uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .buf_q(buf_q),
    .sck_o(sck_o), .sdo_o(sdo_o), .sdi_i(sdi_i), .irq_o(irq_o)
  );

  // bit i of a byte as it appears on the wire
  function automatic logic [7:0] wire_order(input logic [7:0] b, input logic msb);
    logic [7:0] w;
    for (int i = 0; i < 8; i++) w[i] = msb ? b[7-i] : b[i];
    return w;
  endfunction

  function automatic logic [7:0] ctl_word(input bit run, input bit msb, input bit cont,
                                          input bit idle, input bit ien,
                                          input bit dn, input bit ov);
    return {1'b0, ov, dn, ien, idle, cont, msb, run};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic prep();
    slv_idx = 0;
    cap_idx = 0;
    cap_seq = '0;
    sdi_i   = slv_seq[0];
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // serial partner: capture on rising clock, advance its data on falling clock
  initial begin
    forever begin
      @(posedge sck_o);
      if (cap_idx < 32) cap_seq[cap_idx] = sdo_o;
      cap_idx++;
      @(negedge sck_o);
      slv_idx++;
      if (slv_idx < 32) sdi_i = slv_seq[slv_idx];
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    cycles(3);
    // R1 reset state
    check("R1 ctrl", ctrl_q, 8'h00);
    check("R1 buf", buf_q, 8'h00);
    check("R1 pins", {sck_o, sdo_o, irq_o}, 3'b000);
    rst_n = 1'b1;
    cycles(2);
    check("R1 ctrl after release", ctrl_q, 8'h00);

    // random single-byte transfers
    for (int it = 0; it < 8; it++) begin
      logic [7:0] baud, tx, sl;
      bit msb, pol, ien;
      int h;
      baud = 8'd248 + 8'($urandom % 8);
      h = 256 - int'(baud);
      tx = 8'($urandom); sl = 8'($urandom);
      msb = 1'($urandom); pol = 1'($urandom); ien = 1'($urandom);
      wr(2'd2, baud);
      wr(2'd1, tx);
      slv_seq = {24'd0, wire_order(sl, msb)};
      prep();
      wr(2'd0, ctl_word(1, msb, 0, pol, ien, 0, 0));
      cycles(16*h - 1);
      check("R2 end flag not yet", ctrl_q[5], 1'b0);
      check("R5 run during transfer", ctrl_q[0], 1'b1);
      cycles(1);
      check("R2 end flag on time", ctrl_q[5], 1'b1);
      check("R5 run self-cleared", ctrl_q[0], 1'b0);
      check("R5 clock idle low", sck_o, 1'b0);
      check("R3 bit count", cap_idx, 8);
      check("R3 wire order", cap_seq[7:0], wire_order(tx, msb));
      check("R4 received byte", buf_q, sl);
      check("R10 idle level", sdo_o, pol ? sl[0] : (msb ? tx[0] : tx[7]));
      check("R11 irq", irq_o, ien);
      wr(2'd0, ctl_word(0, msb, 0, pol, ien, 1, 0));
      check("R6 write 1 keeps end flag", ctrl_q[5], 1'b1);
      wr(2'd0, ctl_word(0, msb, 0, pol, ien, 0, 0));
      check("R6 write 0 clears end flag", ctrl_q[5], 1'b0);
      check("R11 irq low after clear", irq_o, 1'b0);
    end

    // continuous mode with overrun, then abort
    begin
      logic [7:0] s1, s2;
      s1 = 8'h3C; s2 = 8'h81;
      wr(2'd2, 8'd254);
      wr(2'd1, 8'hA5);
      slv_seq = {8'd0, 8'd0, wire_order(s2, 0), wire_order(s1, 0)};
      prep();
      wr(2'd0, ctl_word(1, 0, 1, 0, 1, 0, 0));
      cycles(31);
      check("R8 end flag not yet", ctrl_q[5], 1'b0);
      cycles(1);
      check("R8 end flag first byte", ctrl_q[5], 1'b1);
      check("R8 run stays set", ctrl_q[0], 1'b1);
      check("R11 irq continuous", irq_o, 1'b1);
      cycles(3);
      check("R7 no overrun before fall", ctrl_q[6], 1'b0);
      cycles(1);
      check("R7 overrun at first fall", ctrl_q[6], 1'b1);
      cycles(28);
      check("R8 first byte on wire", cap_seq[7:0], wire_order(8'hA5, 0));
      check("R8 resent received byte", cap_seq[15:8], wire_order(s1, 0));
      check("R8 buffer after second byte", buf_q, s2);
      check("R8 run still set", ctrl_q[0], 1'b1);
      wr(2'd0, ctl_word(0, 0, 1, 0, 1, 1, 1));
      check("R9 run cleared by abort", ctrl_q[0], 1'b0);
      check("R9 clock low after abort", sck_o, 1'b0);
      cycles(20);
      check("R9 clock stays low", sck_o, 1'b0);
      check("R9 buffer unchanged", buf_q, s2);
      check("R7 overrun sticky", ctrl_q[6], 1'b1);
      wr(2'd0, ctl_word(0, 0, 0, 0, 0, 1, 0));
      check("R7 overrun cleared", ctrl_q[6], 1'b0);
      wr(2'd0, ctl_word(0, 0, 0, 0, 0, 0, 0));
    end

    // abort in single mode does not set the end flag
    wr(2'd2, 8'd252);
    wr(2'd1, 8'h5A);
    slv_seq = '0;
    prep();
    wr(2'd0, ctl_word(1, 0, 0, 0, 1, 0, 0));
    cycles(10);
    wr(2'd0, ctl_word(0, 0, 0, 0, 1, 0, 0));
    check("R9 run cleared", ctrl_q[0], 1'b0);
    check("R9 end flag clear", ctrl_q[5], 1'b0);
    cycles(100);
    check("R9 end flag stays clear", ctrl_q[5], 1'b0);
    check("R9 clock idle", sck_o, 1'b0);
    check("R11 no irq after abort", irq_o, 1'b0);

    // buffer write during a transfer is ignored
    wr(2'd2, 8'd255);
    wr(2'd1, 8'hC3);
    slv_seq = {24'd0, wire_order(8'h96, 1)};
    prep();
    wr(2'd0, ctl_word(1, 1, 0, 0, 0, 0, 0));
    wr(2'd1, 8'hFF);
    cycles(20);
    check("R12 buffer write ignored", buf_q, 8'h96);
    check("R3 msb first at fastest rate", cap_seq[7:0], wire_order(8'hC3, 1));
    wr(2'd0, ctl_word(0, 1, 0, 1, 0, 0, 0));
    check("R10 idle drives buffer bit 0", sdo_o, 1'b0);
    wr(2'd0, ctl_word(0, 1, 0, 0, 0, 0, 0));
    check("R10 idle holds last bit", sdo_o, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule